// File: doc/BRIEF.md
# Prime-Alphabet Galois Shift Register

This block is a Galois-form feedback shift register in which every cell stores a symbol from the set {0 .. Q-1}, where Q is a small prime chosen by parameter. Cell 0 is the output end. On each enabled clock the symbol in cell 0 is sent back into the register. Every cell takes the value of its higher-numbered neighbour plus the fed-back symbol multiplied by that cell's fixed tap constant, with the result reduced modulo Q. The top cell has no neighbour, so it receives only the weighted feedback. With Q = 2 and constants of 0 or 1, this is an ordinary binary Galois register with XOR feedback.

A small controller has two states. **ST_EMPTY** is entered on reset. It leaves to **ST_READY** on the transition *seed_load*, which happens whenever `load_i` is high. In ST_READY the controller issues one of three update commands each cycle: **UPD_LOAD** when `load_i` is high, **UPD_STEP** when `en_i` is high and `load_i` is low, and **UPD_KEEP** otherwise. In ST_EMPTY, only UPD_LOAD or UPD_KEEP is issued. Only a reset returns the controller to ST_EMPTY, on the transition *reset_clear*.

Top module: `lfsr_q_galois`

## Requirements
- R1: Each cell is $clog2(Q) bits wide. Every value stored, and every value on `sym_o`, is below Q at all times after reset.
- R2: A synchronous active-high `rst_i` clears all cells to 0 and puts the controller in ST_EMPTY. `sym_o` reads 0 in the cycle after reset.
- R3: When `load_i` is high, cell i takes `seed_i[i*SYMW +: SYMW]` reduced modulo Q (for Q = 3, a seed symbol of 3 is stored as 0). `sym_o` shows the new cell 0 one cycle later. Load takes priority over `en_i`.
- R4: When `en_i` is high and `load_i` is low in ST_READY, each cell i < LEN-1 takes (cell[i+1] + cell0 * K[i]) mod Q, and the top cell takes (cell0 * K[LEN-1]) mod Q. K[i] is `COEFF[i*SYMW +: SYMW]`, and `sym_o` is cell 0.
- R5: With `en_i` and `load_i` both low, every cell holds its value and `sym_o` is unchanged.
- R6: In ST_EMPTY, `en_i` is ignored: `sym_o` stays 0 until a seed is loaded.
- R7: A tap constant of 0 means no feedback at that cell, so the cell takes its neighbour's value unchanged.
- R8: With Q = 2, LEN = 4 and constants taken from mask 4'b1100, the output stream matches the binary model `s = (s >> 1) ^ (s[0] ? 4'hC : 0)`.
- R9: With Q = 3, LEN = 2, K[0] = 2 and K[1] = 1 (polynomial x^2 + x + 2), and seed cell0 = 1, cell1 = 0, `sym_o` runs through 1,2,2,0,2,1,1,0 and repeats with period 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the register one step |
| load_i | input | 1 | Load the seed (overrides en_i) |
| seed_i | input | LEN*SYMW | Seed symbols, cell i at bits [i*SYMW +: SYMW] |
| sym_o | output | SYMW | Output symbol (cell 0) |

## Verification
Every result is due exactly one clock edge after its stimulus. This applies to a load, a step, a hold and a reset alike, because `sym_o` is taken directly from the cell 0 register with no further stage. The bench drives inputs on the falling edge and samples `sym_o` on the next falling edge. Each sample therefore reflects exactly one rising edge of update. The period check walks an expected-symbol table over two full cycles, one step per clock. The binary instance is compared at each step against a mask-XOR model that advances in the same half-cycle.

// File: rtl/lfsr_q_pkg.sv
package lfsr_q_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_READY = 1'b1
    } lfsr_st_t;

    typedef enum logic [1:0] {
        UPD_KEEP = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } lfsr_upd_t;

endpackage

// File: rtl/lfsr_q_ctrl.sv
module lfsr_q_ctrl
    import lfsr_q_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      load_i,
    output lfsr_st_t  state_o,
    output lfsr_upd_t upd_o
);

    lfsr_st_t state_q;
    lfsr_st_t state_d;

    // State register process
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: seed_load moves EMPTY to READY, READY is held
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (load_i) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Output process: update command for the cell array
    always_comb begin
        upd_o = UPD_KEEP;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_i) upd_o = UPD_LOAD;
            end
            ST_READY: begin
                if (load_i)    upd_o = UPD_LOAD;
                else if (en_i) upd_o = UPD_STEP;
            end
            default: upd_o = UPD_KEEP;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/lfsr_q_mac.sv
// (nb + fb * K) mod Q in combinational logic, through a widened sum.
module lfsr_q_mac #(
    parameter int Q    = 3,
    parameter int SYMW = $clog2(Q),
    parameter int K    = 1
) (
    input  logic [SYMW-1:0] nb_i,
    input  logic [SYMW-1:0] fb_i,
    output logic [SYMW-1:0] res_o
);

    localparam int WW = 2 * SYMW + 2;
    localparam int KR = K % Q;

    logic [WW-1:0] wide;
    logic [WW-1:0] red;

    always_comb begin
        wide  = WW'(nb_i) + WW'(fb_i) * WW'(KR);
        red   = wide % WW'(Q);
        res_o = red[SYMW-1:0];
    end

endmodule

// File: rtl/lfsr_q_cell.sv
module lfsr_q_cell
    import lfsr_q_pkg::*;
#(
    parameter int Q    = 3,
    parameter int SYMW = $clog2(Q)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  lfsr_upd_t       upd_i,
    input  logic [SYMW-1:0] seed_i,
    input  logic [SYMW-1:0] step_i,
    output logic [SYMW-1:0] val_o
);

    localparam int SW = SYMW + 1;

    logic [SW-1:0]   seed_red;
    logic [SYMW-1:0] val_q;

    assign seed_red = SW'(seed_i) % SW'(Q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q <= '0;
        end else begin
            unique case (upd_i)
                UPD_LOAD: val_q <= seed_red[SYMW-1:0];
                UPD_STEP: val_q <= step_i;
                UPD_KEEP: val_q <= val_q;
                default:  val_q <= val_q;
            endcase
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/lfsr_q_galois.sv
module lfsr_q_galois
    import lfsr_q_pkg::*;
#(
    parameter int Q   = 3,
    parameter int LEN = 2,
    parameter logic [LEN*$clog2(Q)-1:0] COEFF = 4'b0110
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      en_i,
    input  logic                      load_i,
    input  logic [LEN*$clog2(Q)-1:0]  seed_i,
    output logic [$clog2(Q)-1:0]      sym_o
);

    localparam int SYMW = $clog2(Q);
    localparam int VW   = LEN * SYMW;

    lfsr_st_t        state;
    lfsr_upd_t       upd;
    logic [VW-1:0]   cells;
    logic [VW-1:0]   nxt;
    logic [SYMW-1:0] fb;

    lfsr_q_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .load_i  (load_i),
        .state_o (state),
        .upd_o   (upd)
    );

    assign fb = cells[SYMW-1:0];

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        logic [SYMW-1:0] nb;
        if (i == LEN - 1) begin : g_top
            assign nb = '0;
        end else begin : g_mid
            assign nb = cells[(i+1)*SYMW +: SYMW];
        end

        lfsr_q_mac #(
            .Q    (Q),
            .SYMW (SYMW),
            .K    (int'(COEFF[i*SYMW +: SYMW]))
        ) u_mac (
            .nb_i  (nb),
            .fb_i  (fb),
            .res_o (nxt[i*SYMW +: SYMW])
        );

        lfsr_q_cell #(
            .Q    (Q),
            .SYMW (SYMW)
        ) u_cell (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .upd_i  (upd),
            .seed_i (seed_i[i*SYMW +: SYMW]),
            .step_i (nxt[i*SYMW +: SYMW]),
            .val_o  (cells[i*SYMW +: SYMW])
        );
    end

    assign sym_o = fb;

endmodule

// File: rtl/lfsr_q_galois_chk.sv
module lfsr_q_galois_chk
    import lfsr_q_pkg::*;
#(
    parameter int Q   = 3,
    parameter int LEN = 2,
    parameter logic [LEN*$clog2(Q)-1:0] COEFF = 4'b0110
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     en_i,
    input logic                     load_i,
    input logic [LEN*$clog2(Q)-1:0] seed_i,
    input logic [$clog2(Q)-1:0]     sym_o,
    input logic [LEN*$clog2(Q)-1:0] cells,
    input lfsr_st_t                 state
);

    localparam int SYMW = $clog2(Q);
    localparam int WW   = 2 * SYMW + 2;
    localparam int K0   = int'(COEFF[SYMW-1:0]) % Q;

    logic [SYMW-1:0] nb1;
    logic [WW-1:0]   exp_step;
    logic [WW-1:0]   exp_seed;

    if (LEN > 1) begin : g_nb
        assign nb1 = cells[2*SYMW-1:SYMW];
    end else begin : g_nb0
        assign nb1 = '0;
    end

    assign exp_step = (WW'(nb1) + WW'(sym_o) * WW'(K0)) % WW'(Q);
    assign exp_seed = WW'(seed_i[SYMW-1:0]) % WW'(Q);

    assert_sym_below_q_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(sym_o) < Q);

    assert_reset_clear_R2: assert property (@(posedge clk_i)
        rst_i |=> (sym_o == '0));

    assert_seed_load_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (WW'(sym_o) == $past(exp_seed)));

    assert_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !load_i && state == ST_READY) |=> (WW'(sym_o) == $past(exp_step)));

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !load_i) |=> $stable(cells));

    assert_empty_ignores_en_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_EMPTY && !load_i) |=> (sym_o == '0));

endmodule

bind lfsr_q_galois lfsr_q_galois_chk #(
    .Q     (Q),
    .LEN   (LEN),
    .COEFF (COEFF)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .load_i (load_i),
    .seed_i (seed_i),
    .sym_o  (sym_o),
    .cells  (cells),
    .state  (state)
);

// File: tb/test_lfsr_q_galois.sv
`timescale 1ns/1ps
module test_lfsr_q_galois;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk; // 50 MHz

    // Ternary instance: x^2 + x + 2, K0=2, K1=1
    logic       en3 = 1'b0, ld3 = 1'b0;
    logic [3:0] seed3 = '0;
    logic [1:0] sym3;

    // Binary instance: mask 4'b1100
    logic       en2 = 1'b0, ld2 = 1'b0;
    logic [3:0] seed2 = '0;
    logic [0:0] sym2;

    lfsr_q_galois #(.Q(3), .LEN(2), .COEFF(4'b0110)) i_lfsr_q_galois (
        .clk_i(clk), .rst_i(rst), .en_i(en3), .load_i(ld3),
        .seed_i(seed3), .sym_o(sym3)
    );

    lfsr_q_galois #(.Q(2), .LEN(4), .COEFF(4'b1100)) i_lfsr_q_galois_bin (
        .clk_i(clk), .rst_i(rst), .en_i(en2), .load_i(ld2),
        .seed_i(seed2), .sym_o(sym2)
    );

    localparam int PERIOD = 8;
    localparam logic [1:0] EXP3 [PERIOD] = '{2'd1, 2'd2, 2'd2, 2'd0, 2'd2, 2'd1, 2'd1, 2'd0};

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] m;
        @(negedge clk);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        // R2: reset state
        chk("R2 reset clears ternary", int'(sym3), 0);
        chk("R2 reset clears binary", int'(sym2), 0);

        // R6: enable ignored before seed
        en3 = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R6 empty ignores en", int'(sym3), 0);
        end
        en3 = 1'b0;

        // R9 / R4 / R1: period table walked twice
        seed3 = 4'b0001; ld3 = 1'b1;
        tick();
        ld3 = 1'b0;
        chk("R9 seed symbol", int'(sym3), int'(EXP3[0]));
        en3 = 1'b1;
        for (int i = 1; i <= 2 * PERIOD; i++) begin
            tick();
            chk("R9 R4 period step", int'(sym3), int'(EXP3[i % PERIOD]));
            chk("R1 symbol below Q", int'(sym3 < 2'd3), 1);
        end
        en3 = 1'b0;

        // R5: hold with enable low (state (1,0) -> step would give 2)
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 hold", int'(sym3), 1);
        end
        en3 = 1'b1; tick(); en3 = 1'b0;
        chk("R5 resumes after hold", int'(sym3), 2);

        // R3: load overrides enable
        seed3 = 4'b0001; ld3 = 1'b1; en3 = 1'b1;
        tick();
        ld3 = 1'b0; en3 = 1'b0;
        chk("R3 load beats enable", int'(sym3), 1);

        // R3: out-of-range seed symbol reduced: cell0=3->0, cell1=2
        seed3 = 4'b1011; ld3 = 1'b1;
        tick();
        ld3 = 1'b0;
        chk("R3 seed reduced mod Q", int'(sym3), 0);
        en3 = 1'b1;
        tick();
        chk("R3 R4 step after reduced seed", int'(sym3), 2);
        tick();
        chk("R4 weighted feedback", int'(sym3), 1);
        en3 = 1'b0;

        // R8 / R7: binary instance against mask model
        seed2 = 4'b1001; ld2 = 1'b1;
        m = 4'b1001;
        tick();
        ld2 = 1'b0;
        chk("R8 binary seed", int'(sym2), int'(m[0]));
        en2 = 1'b1;
        for (int i = 0; i < 20; i++) begin
            m = (m >> 1) ^ (m[0] ? 4'hC : 4'h0);
            tick();
            chk("R8 R7 binary stream", int'(sym2), int'(m[0]));
        end
        en2 = 1'b0;

        // R2: reset after activity
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R2 reset after run", int'(sym3), 0);
        chk("R2 reset after run binary", int'(sym2), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule